// File: doc/BRIEF.md
# Configurable Interrupt Trigger Cell

This block turns eight asynchronous event lines into eight pending interrupt flags. Each line has its own trigger setting. In edge mode, the line can trigger on a rising edge, a falling edge, or both, and the pending flag stays set until it is cleared. In level mode, the line is active-high or active-low, and the pending flag follows the active level. Every input is synchronized before it is examined.

Software programs the group through one byte-wide configuration port. A single write byte does three things:
- It names the target line in bits 6:4.
- It carries the trigger setting in bits 2:0, which is stored only when bit 7 is set.
- It can drop the target line's pending flag through bit 3.

The read port always shows the stored setting of the line named by the most recent write. A write with bit 7 clear is therefore how software selects a line for readback.

Top module: `irq_trigger_cell`

## Requirements
- R1: After reset every pending flag is 0, and every line reads back 0x06: edge mode, both masks set, which means fully masked.
- R2: A write with bit 7 set stores bits 2:0 into the line named by bits 6:4. Bit 0 is level mode, bit 1 masks the falling direction and bit 2 masks the rising direction. The read port then returns {0, index[2:0], 0, stored[2:0]}.
- R3: A write with bit 7 clear changes no stored setting and only selects the line. The read port then returns that line's stored setting.
- R4: In edge mode with only the rising mask clear (setting 0b010), a 0-to-1 transition sets the pending flag and a 1-to-0 transition does not. The flag stays set while the input returns low.
- R5: In edge mode with only the falling mask clear (setting 0b100), a 1-to-0 transition sets the flag and a 0-to-1 transition does not.
- R6: In edge mode with both masks clear (setting 0b000), either transition sets the flag.
- R7: A line with both masks set never raises its pending flag, whatever its input does.
- R8: A write with bit 3 set drops the target line's edge-mode pending flag in the cycle after the write, with or without bit 7. It leaves the other lines untouched, and bit 3 always reads back as 0.
- R9: In level mode with the rising mask clear (0b011), the flag is 1 while the input is high. With the falling mask clear (0b101), it is 1 while the input is low. A clear command does not hold it low while the level stays active.
- R10: A change at a line input reaches its pending flag on the third rising clock edge after the change, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 8 | Asynchronous event lines |
| cfg_wr_en | input | 1 | One-cycle strobe that accepts cfg_wr_data |
| cfg_wr_data | input | 8 | Configuration byte: store flag, index, clear and setting |
| cfg_rd_data | output | 8 | Stored setting of the last addressed line |
| pending | output | 8 | Pending flag of each line |

## Verification
The properties assume two things. First, cfg_wr_data is meaningful only in cycles where cfg_wr_en is high. Second, the readback port changes only through a write. The bench drives the strobe for exactly one cycle per write and returns it low afterwards, so no write is ever spread over two cycles.

The masked-line property also assumes that the stored setting seen on the read port is the one in force for that cycle. The stimulus therefore changes line inputs only on falling clock edges, and it changes them well apart from configuration writes to the same line.

// File: rtl/irq_trigger_pkg.sv
// Shared types and field positions for the configurable interrupt trigger cell.
package irq_trigger_pkg;

    // Stored per-line trigger setting; packed so bit 0 = level, 1 = mask falling, 2 = mask rising.
    typedef struct packed {
        logic mask_rise;
        logic mask_fall;
        logic level;
    } trig_cfg_t;

    localparam int CFG_SET_W   = 3;
    localparam int CFG_BIT_CLR = 3;
    localparam int CFG_IDX_LSB = 4;
    localparam int CFG_IDX_W   = 3;
    localparam int CFG_BIT_WE  = 7;
    localparam int CFG_BYTE_W  = 8;

    // Reset setting: edge mode, both directions masked.
    localparam trig_cfg_t CFG_RESET = '{mask_rise: 1'b1, mask_fall: 1'b1, level: 1'b0};

endpackage

// File: rtl/irq_line_sync.sv
// Multi-bit synchronizer chain for the asynchronous event lines.
// Assumes each bit is an independent signal; no cross-bit coherence is implied.
module irq_line_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the inputs through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/irq_cfg_regs.sv
// Configuration storage for one group of lines.
// It decodes the config byte into a line index, a store flag and a clear command.
// It holds one setting per line and the last addressed index, and returns readback.
// Assumes cfg_wr_data is valid only while cfg_wr_en is high.
module irq_cfg_regs
    import irq_trigger_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr_en,
    input  logic [CFG_BYTE_W-1:0] cfg_wr_data,
    output logic [CFG_BYTE_W-1:0] cfg_rd_data,
    output trig_cfg_t             line_cfg  [NUM_LINES],
    output logic [NUM_LINES-1:0]  clr_pulse
);

    localparam int SEL_W = CFG_IDX_W;

    logic [SEL_W-1:0]     wr_idx;
    logic                 wr_store;
    logic                 wr_clear;
    trig_cfg_t            wr_set;
    logic [SEL_W-1:0]     sel_q;
    trig_cfg_t            cfg_q [NUM_LINES];
    trig_cfg_t            rd_set;

    // Split the incoming byte into its fields.
    always_comb begin
        wr_idx   = cfg_wr_data[CFG_IDX_LSB +: CFG_IDX_W];
        wr_store = cfg_wr_data[CFG_BIT_WE];
        wr_clear = cfg_wr_data[CFG_BIT_CLR];
        wr_set   = trig_cfg_t'(cfg_wr_data[CFG_SET_W-1:0]);
    end

    // Remember which line the last write addressed.
    always_ff @(posedge clk) begin
        if (!rst_n)         sel_q <= '0;
        else if (cfg_wr_en) sel_q <= wr_idx;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_LINES; gi++) begin : g_line
            // Store this line's setting when a write with the store flag targets it.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cfg_q[gi] <= CFG_RESET;
                else if (cfg_wr_en && wr_store && (wr_idx == SEL_W'(gi)))
                    cfg_q[gi] <= wr_set;
            end

            // One-cycle clear request for this line; never stored.
            assign clr_pulse[gi] = cfg_wr_en && wr_clear && (wr_idx == SEL_W'(gi));
            assign line_cfg[gi]  = cfg_q[gi];
        end
    endgenerate

    // Select the addressed line's setting for readback.
    always_comb begin
        rd_set = CFG_RESET;
        for (int k = 0; k < NUM_LINES; k++)
            if (sel_q == SEL_W'(k)) rd_set = cfg_q[k];
    end

    // Assemble the readback byte: store and clear positions read as zero.
    always_comb begin
        cfg_rd_data                                = '0;
        cfg_rd_data[CFG_SET_W-1:0]                 = rd_set;
        cfg_rd_data[CFG_IDX_LSB +: CFG_IDX_W]      = sel_q;
    end

endmodule

// File: rtl/irq_line_detect.sv
// Trigger logic for one line: edge detection against the previous sample and the pending latch.
// Assumes sync_in is already synchronized to clk.
module irq_line_detect
    import irq_trigger_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sync_in,
    input  trig_cfg_t cfg,
    input  logic      clr,
    output logic      pending
);

    logic prev_q;
    logic pend_q;
    logic rise_evt;
    logic fall_evt;
    logic lvl_active;

    // Keep the previous synchronized sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_in;
    end

    // Derive unmasked edge events and the unmasked level condition.
    always_comb begin
        rise_evt   = sync_in && !prev_q && !cfg.mask_rise;
        fall_evt   = !sync_in && prev_q && !cfg.mask_fall;
        lvl_active = (sync_in && !cfg.mask_rise) || (!sync_in && !cfg.mask_fall);
    end

    // Pending: follows the level in level mode; sticky in edge mode, where a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (cfg.level)
            pend_q <= lvl_active;
        else
            pend_q <= (pend_q && !clr) || rise_evt || fall_evt;
    end

    assign pending = pend_q;

endmodule

// File: rtl/irq_trigger_cell.sv
// Top of the configurable interrupt trigger cell: a synchronizer, per-line detectors and config storage.
// Assumes one byte-wide write strobe per configuration access; readback is combinational from storage.
module irq_trigger_cell
    import irq_trigger_pkg::*;
#(
    parameter int NUM_LINES   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_in,
    input  logic                 cfg_wr_en,
    input  logic [7:0]           cfg_wr_data,
    output logic [7:0]           cfg_rd_data,
    output logic [NUM_LINES-1:0] pending
);

    logic [NUM_LINES-1:0] line_sync;
    logic [NUM_LINES-1:0] clr_pulse;
    trig_cfg_t            line_cfg [NUM_LINES];

    irq_line_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (line_in),
        .sync_out (line_sync)
    );

    irq_cfg_regs #(
        .NUM_LINES (NUM_LINES)
    ) cfg_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .cfg_rd_data (cfg_rd_data),
        .line_cfg    (line_cfg),
        .clr_pulse   (clr_pulse)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NUM_LINES; gi++) begin : g_det
            irq_line_detect det_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .sync_in (line_sync[gi]),
                .cfg     (line_cfg[gi]),
                .clr     (clr_pulse[gi]),
                .pending (pending[gi])
            );
        end
    endgenerate

endmodule

// File: rtl/irq_trigger_cell_checker.sv
// Port-level properties of the trigger cell, attached to the top module with bind.
module irq_trigger_cell_checker #(
    parameter int NUM_LINES = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_wr_en,
    input logic [7:0]           cfg_wr_data,
    input logic [7:0]           cfg_rd_data,
    input logic [NUM_LINES-1:0] pending
);

    // R1: a reset cycle leaves no pending flag.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> pending == '0);

    // R2: a storing write is read back in the next cycle.
    assert_store_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_wr_data[7]) |=> cfg_rd_data[2:0] == $past(cfg_wr_data[2:0]));

    // R2: every write moves the readback index to the written one.
    assert_index_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> cfg_rd_data[6:4] == $past(cfg_wr_data[6:4]));

    // R3: a non-storing write to the already addressed line changes nothing visible.
    assert_select_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && !cfg_wr_data[7] && cfg_wr_data[6:4] == cfg_rd_data[6:4])
        |=> $stable(cfg_rd_data));

    // R8: the store and clear positions always read as zero.
    assert_rd_zero_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd_data[7] && !cfg_rd_data[3]);

    // R7: a fully masked edge-mode line that is not pending stays not pending.
    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr_en && cfg_rd_data[2:0] == 3'b110 && !pending[cfg_rd_data[6:4]])
        |=> !pending[$past(cfg_rd_data[6:4])]);

endmodule

bind irq_trigger_cell irq_trigger_cell_checker #(
    .NUM_LINES (NUM_LINES)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .cfg_rd_data (cfg_rd_data),
    .pending     (pending)
);

// File: tb/irq_trigger_cell_tb_top.sv
`timescale 1ns/1ps
// Directed bench for the trigger cell: one task per scenario, each checking its own results.
module irq_trigger_cell_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] line_in = '0;
    logic       cfg_wr_en = 1'b0;
    logic [7:0] cfg_wr_data = '0;
    logic [7:0] cfg_rd_data;
    logic [7:0] pending;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    irq_trigger_cell dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_in     (line_in),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .cfg_rd_data (cfg_rd_data),
        .pending     (pending)
    );

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // One-cycle config write; returns at the following falling edge.
    task automatic wr(input bit store, input bit clr, input logic [2:0] idx, input logic [2:0] set);
        cfg_wr_data = {store, idx, clr, set};
        cfg_wr_en   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_wr_en   = 1'b0;
        cfg_wr_data = '0;
    endtask

    task automatic t_reset;
        check("R1", "pending after reset", pending, 8'h00);
        for (int i = 0; i < 8; i++) begin
            wr(1'b0, 1'b0, 3'(i), 3'b000);
            check("R1", "reset readback", cfg_rd_data, {1'b0, 3'(i), 4'b0110});
        end
    endtask

    task automatic t_store_select;
        wr(1'b1, 1'b0, 3'd2, 3'b010);
        check("R2", "store readback line 2", cfg_rd_data, 8'h22);
        wr(1'b0, 1'b0, 3'd5, 3'b001);
        check("R3", "select-only keeps line 5", cfg_rd_data, 8'h56);
        wr(1'b0, 1'b0, 3'd2, 3'b111);
        check("R3", "select returns line 2", cfg_rd_data, 8'h22);
    endtask

    task automatic t_rise;
        wr(1'b1, 1'b0, 3'd0, 3'b010);
        line_in[0] = 1'b1;
        tick(2);
        check("R10", "no flag after two edges", pending & 8'h01, 8'h00);
        tick(1);
        check("R10", "flag on third edge", pending & 8'h01, 8'h01);
        line_in[0] = 1'b0;
        tick(4);
        check("R4", "rising flag sticky", pending & 8'h01, 8'h01);
        wr(1'b1, 1'b1, 3'd0, 3'b010);
        check("R8", "clear drops line 0", pending & 8'h01, 8'h00);
        check("R8", "clear bit not stored", cfg_rd_data, 8'h02);
        line_in[0] = 1'b1; tick(4);
        wr(1'b0, 1'b1, 3'd0, 3'b000);
        check("R8", "clear without store flag", pending & 8'h01, 8'h00);
        line_in[0] = 1'b0; tick(4);
        check("R4", "falling ignored", pending & 8'h01, 8'h00);
    endtask

    task automatic t_fall;
        wr(1'b1, 1'b0, 3'd1, 3'b100);
        line_in[1] = 1'b1; tick(4);
        check("R5", "rising ignored", pending & 8'h02, 8'h00);
        line_in[1] = 1'b0; tick(4);
        check("R5", "falling sets", pending & 8'h02, 8'h02);
    endtask

    task automatic t_both;
        wr(1'b1, 1'b0, 3'd2, 3'b000);
        line_in[2] = 1'b1; tick(4);
        check("R6", "both-edge rising", pending & 8'h04, 8'h04);
        wr(1'b0, 1'b1, 3'd2, 3'b000);
        check("R8", "other line kept", pending & 8'h02, 8'h02);
        check("R6", "cleared", pending & 8'h04, 8'h00);
        line_in[2] = 1'b0; tick(4);
        check("R6", "both-edge falling", pending & 8'h04, 8'h04);
    endtask

    task automatic t_masked;
        line_in[3] = 1'b1; tick(4);
        line_in[3] = 1'b0; tick(4);
        check("R7", "masked line quiet", pending & 8'h08, 8'h00);
    endtask

    task automatic t_level;
        wr(1'b1, 1'b0, 3'd4, 3'b011);
        line_in[4] = 1'b1; tick(3);
        check("R9", "active-high set", pending & 8'h10, 8'h10);
        wr(1'b0, 1'b1, 3'd4, 3'b000);
        tick(1);
        check("R9", "clear ineffective while high", pending & 8'h10, 8'h10);
        line_in[4] = 1'b0; tick(3);
        check("R9", "active-high follows low", pending & 8'h10, 8'h00);
        wr(1'b1, 1'b0, 3'd5, 3'b101);
        tick(1);
        check("R9", "active-low set while low", pending & 8'h20, 8'h20);
        line_in[5] = 1'b1; tick(3);
        check("R9", "active-low drops when high", pending & 8'h20, 8'h00);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_store_select();
        t_rise();
        t_fall();
        t_both();
        t_masked();
        t_level();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #40000;
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule